// File: doc/BRIEF.md
# Palette Fade-to-Black Engine

This block keeps a local copy of a 256-colour palette, three 8-bit components per colour, 768 bytes in all. A host loads the copy byte by byte while the engine is idle. A start command with a step count then fades the copy toward black. In each step every component above zero is lowered by a fixed amount, clamped at zero. The updated copy is then pushed out through a palette port: one index write of zero, followed by the bytes in ascending address order. The receiving side advances its own address after each byte.

The picture must not be disturbed, so bytes are sent only inside a vertical retrace window. The engine splits each upload into chunks of 128 colours (384 bytes) and sends one chunk per window, which means two windows per step. Before each chunk it waits for the synchronised retrace level to go low and then high again. A window that is already open when the engine becomes ready, and that may be close to its end, is therefore never used. When the final byte of the final step has gone out, a one-cycle done pulse follows.

Top module: `palette_fader`

## Requirements
- R1: Right after reset, `palIdxWr`, `palDataWr` and `done` are all low.
- R2: Each fade step replaces every byte v of the palette copy with v-STEP when v > STEP, and with 0 otherwise. STEP defaults to 1, so a byte at 0 stays 0 and a byte at 1 becomes 0.
- R3: Each step's upload begins with exactly one `palIdxWr` cycle carrying `palByte` = 0. It is followed by 768 `palDataWr` cycles carrying bytes 0 to 767 of the copy in ascending address order. The address of a byte is 3*colour + component, with components in red, green, blue order.
- R4: The data strobes of an upload arrive in two unbroken bursts of exactly 384 consecutive cycles each.
- R5: Each burst starts only after the retrace input has gone from low to high since the engine became ready for it. A window that is already open when the engine is ready is skipped.
- R6: A start with `stepsReq` = N runs exactly N steps. N = 0 produces no palette writes and only a done pulse.
- R7: `done` is high for exactly one cycle per run, in the cycle after the last data byte of the last step.
- R8: A start that arrives while a run is in progress is ignored.
- R9: A host write (`hostWe`, `hostAddr`, `hostData`) loads one byte while the engine is idle. While a run is in progress, a host write is ignored.
- R10: The faded copy is kept between runs, so a later run continues from where the previous one ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a fade run (accepted only when idle) |
| stepsReq | input | 9 | Number of fade steps for the run |
| retrace | input | 1 | Vertical retrace level, high inside a window (asynchronous) |
| hostWe | input | 1 | Host byte write enable |
| hostAddr | input | 10 | Host byte address, 0 to 767 |
| hostData | input | 8 | Host byte value |
| palIdxWr | output | 1 | Palette index write strobe |
| palDataWr | output | 1 | Palette data write strobe |
| palByte | output | 8 | Index value or data byte for the strobe |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The fade is run on two palettes. The first mixes zeros, ones and random bytes, which separates a clamped subtraction from a wrapping one. The second is an address ramp, which exposes any reordering or dropping of bytes in the stream. Retrace windows of random length, together with a directed start placed inside an unusually long window, show whether the engine waits for a fresh window or uses the one already open. A run with a mid-run start and host write, a zero-step run and back-to-back runs show that busy-time inputs are ignored and that the palette copy is kept between runs.

// File: rtl/pal_fade_pkg.sv
package pal_fade_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrPtr;
    logic incPtr;
    logic decWr;
    logic sendIdx;
    logic sendByte;
    logic hostEn;
  } dpCtl_t;
endpackage

// File: rtl/pal_fade_dp.sv
module pal_fade_dp
  import pal_fade_pkg::*;
#(
  parameter int TOTAL  = 768,
  parameter int COMP_W = 8,
  parameter int STEP   = 1,
  localparam int ADDR_W = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [COMP_W-1:0] hostData,
  output logic              ptrLast,
  output logic              palIdxWr,
  output logic              palDataWr,
  output logic [COMP_W-1:0] palByte
);
  logic [COMP_W-1:0] mem [0:TOTAL-1];
  logic [ADDR_W-1:0] ptr;
  logic [COMP_W-1:0] cur;
  logic [COMP_W-1:0] faded;

  assign cur     = mem[ptr];
  assign faded   = (cur > COMP_W'(STEP)) ? cur - COMP_W'(STEP) : '0;
  assign ptrLast = (ptr == ADDR_W'(TOTAL - 1));

  // palette storage: fade rewrite has priority, host only when idle
  always_ff @(posedge clk) begin
    if (ctl.decWr)
      mem[ptr] <= faded;
    else if (ctl.hostEn && hostWe && (hostAddr < ADDR_W'(TOTAL)))
      mem[hostAddr] <= hostData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      palIdxWr  <= 1'b0;
      palDataWr <= 1'b0;
      palByte   <= '0;
    end else begin
      if (ctl.clrPtr)      ptr <= '0;
      else if (ctl.incPtr) ptr <= ptr + 1'b1;
      palIdxWr  <= ctl.sendIdx;
      palDataWr <= ctl.sendByte;
      if (ctl.sendIdx)       palByte <= '0;
      else if (ctl.sendByte) palByte <= cur;
    end
  end
endmodule

// File: rtl/pal_fade_ctl.sv
module pal_fade_ctl
  import pal_fade_pkg::*;
#(
  parameter int STEPS_W     = 9,
  parameter int CHUNK_BYTES = 384,
  localparam int CB_W = $clog2(CHUNK_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [STEPS_W-1:0] stepsReq,
  input  logic               rtSync,
  input  logic               ptrLast,
  output dpCtl_t             ctl,
  output logic               done
);
  typedef enum logic [2:0] {S_IDLE, S_DEC, S_WEND, S_WBEG, S_IDX, S_SEND, S_FIN} st_t;

  st_t              state, nxt;
  logic [STEPS_W-1:0] stepsLeft;
  logic [CB_W-1:0]  cbCnt;
  logic             firstChunk;
  logic             doneQ;

  assign done = doneQ;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      S_IDLE: begin
        ctl.hostEn = 1'b1;
        if (start) begin
          ctl.clrPtr = 1'b1;
          nxt = (stepsReq == '0) ? S_FIN : S_DEC;
        end
      end
      S_DEC: begin
        ctl.decWr  = 1'b1;
        ctl.incPtr = 1'b1;
        if (ptrLast) begin
          ctl.clrPtr = 1'b1;
          nxt = S_WEND;
        end
      end
      S_WEND: if (!rtSync) nxt = S_WBEG;
      S_WBEG: if (rtSync) nxt = firstChunk ? S_IDX : S_SEND;
      S_IDX: begin
        ctl.sendIdx = 1'b1;
        nxt = S_SEND;
      end
      S_SEND: begin
        ctl.sendByte = 1'b1;
        ctl.incPtr   = 1'b1;
        if (ptrLast) begin
          ctl.clrPtr = 1'b1;
          nxt = (stepsLeft == STEPS_W'(1)) ? S_FIN : S_DEC;
        end else if (cbCnt == CB_W'(CHUNK_BYTES - 1)) begin
          nxt = S_WEND;
        end
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      stepsLeft  <= '0;
      cbCnt      <= '0;
      firstChunk <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= (state == S_FIN);
      if (state == S_IDLE && start) stepsLeft <= stepsReq;
      if (state == S_DEC && ptrLast) firstChunk <= 1'b1;
      if (state == S_IDX) firstChunk <= 1'b0;
      if (state == S_WBEG) cbCnt <= '0;
      else if (state == S_SEND) cbCnt <= cbCnt + 1'b1;
      if (state == S_SEND && ptrLast) stepsLeft <= stepsLeft - 1'b1;
    end
  end
endmodule

// File: rtl/palette_fader.sv
module palette_fader
  import pal_fade_pkg::*;
#(
  parameter int NUM_COLORS   = 256,
  parameter int COMP_W       = 8,
  parameter int CHUNK_COLORS = 128,
  parameter int STEP         = 1,
  parameter int STEPS_W      = 9,
  localparam int TOTAL       = NUM_COLORS * 3,
  localparam int CHUNK_BYTES = CHUNK_COLORS * 3,
  localparam int ADDR_W      = $clog2(TOTAL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [STEPS_W-1:0] stepsReq,
  input  logic               retrace,
  input  logic               hostWe,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [COMP_W-1:0]  hostData,
  output logic               palIdxWr,
  output logic               palDataWr,
  output logic [COMP_W-1:0]  palByte,
  output logic               done
);
  dpCtl_t ctl;
  logic   ptrLast;
  logic   rtMeta, rtSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtMeta <= 1'b0;
      rtSync <= 1'b0;
    end else begin
      rtMeta <= retrace;
      rtSync <= rtMeta;
    end
  end

  pal_fade_ctl #(.STEPS_W(STEPS_W), .CHUNK_BYTES(CHUNK_BYTES)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .stepsReq(stepsReq),
    .rtSync(rtSync), .ptrLast(ptrLast), .ctl(ctl), .done(done)
  );

  pal_fade_dp #(.TOTAL(TOTAL), .COMP_W(COMP_W), .STEP(STEP)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostData(hostData), .ptrLast(ptrLast),
    .palIdxWr(palIdxWr), .palDataWr(palDataWr), .palByte(palByte)
  );
endmodule

// File: rtl/pal_fade_chk.sv
module pal_fade_chk #(
  parameter int CHUNK_BYTES = 384,
  parameter int COMP_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rtSync,
  input logic              palIdxWr,
  input logic              palDataWr,
  input logic [COMP_W-1:0] palByte,
  input logic              done
);
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else       runLen <= palDataWr ? runLen + 1'b1 : '0;
  end

  // R1 / R7: done never lasts longer than one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: the index write carries zero and never overlaps a data write
  a_r3_idx_zero: assert property (@(posedge clk) disable iff (!rstN)
    palIdxWr |-> (palByte == '0) && !palDataWr);

  // R4: a data burst never grows past one chunk
  a_r4_burst_bound: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= 16'(CHUNK_BYTES));

  // R4: every data burst that ends has exactly one chunk of bytes
  a_r4_burst_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(palDataWr) |-> runLen == 16'(CHUNK_BYTES));

  // R5: traffic of a chunk starts only when the synchronised window is open
  a_r5_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (palIdxWr || ($rose(palDataWr) && !$past(palIdxWr))) |-> $past(rtSync, 2));
endmodule

bind palette_fader pal_fade_chk #(.CHUNK_BYTES(CHUNK_BYTES), .COMP_W(COMP_W)) uChk (
  .clk(clk), .rstN(rstN), .rtSync(rtSync), .palIdxWr(palIdxWr),
  .palDataWr(palDataWr), .palByte(palByte), .done(done)
);

// File: tb/palette_fader_test.sv
module palette_fader_test;
  localparam int TOTAL = 768;
  localparam int CHUNK = 384;
  localparam int STEP  = 1;
  localparam int LOGN  = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [8:0] stepsReq = '0;
  logic retrace = 1'b0;
  logic hostWe = 1'b0;
  logic [9:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic palIdxWr, palDataWr, done;
  logic [7:0] palByte;

  always #10 clk = ~clk;

  palette_fader #(.STEP(STEP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .stepsReq(stepsReq),
    .retrace(retrace), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .palIdxWr(palIdxWr), .palDataWr(palDataWr),
    .palByte(palByte), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int model [0:TOTAL-1];
  int expLog [0:LOGN-1];
  int gotLog [0:LOGN-1];
  int expLen, logLen;
  int riseTotal = 0, mark = 0;
  int burstStarts, burstBad, runCnt;
  int doneCnt = 0, doneWide = 0, lenAtDone = -1;
  logic rtPrev = 0, prevAct = 0, prevData = 0, prevDone = 0;
  logic longHigh = 0;

  // retrace generator, driven with nonblocking updates at the clock edge
  int phaseLeft = 600;
  always @(posedge clk) begin
    if (phaseLeft > 1) phaseLeft <= phaseLeft - 1;
    else begin
      retrace <= ~retrace;
      if (retrace) phaseLeft <= 500 + int'($urandom % 400);
      else         phaseLeft <= longHigh ? 2500 : 300 + int'($urandom % 200);
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (retrace && !rtPrev) riseTotal++;
      rtPrev = retrace;
      if ((palIdxWr || palDataWr) && !prevAct) begin
        burstStarts++;
        if (riseTotal <= mark || !retrace) burstBad++;
        mark = riseTotal;
      end
      prevAct = palIdxWr || palDataWr;
      if (palIdxWr && logLen < LOGN) begin gotLog[logLen] = 256 + int'(palByte); logLen++; end
      if (palDataWr && logLen < LOGN) begin gotLog[logLen] = int'(palByte); logLen++; end
      if (palDataWr) runCnt++;
      else begin
        if (prevData && runCnt != CHUNK) burstBad++;
        runCnt = 0;
      end
      prevData = palDataWr;
      if (done) begin
        doneCnt++;
        lenAtDone = logLen;
        if (prevDone) doneWide++;
      end
      prevDone = done;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic hostWrite(input int a, input int d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 10'(a); hostData = 8'(d);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  function automatic int fadeByte(input int v);
    return (v > STEP) ? v - STEP : 0;
  endfunction

  task automatic runFade(input int steps, input bit pokeBusy, input string tag);
    int d0, bs, mismatch, firstBad;
    expLen = 0;
    for (int s = 0; s < steps; s++) begin
      expLog[expLen++] = 256;
      for (int i = 0; i < TOTAL; i++) begin
        model[i] = fadeByte(model[i]);
        expLog[expLen++] = model[i];
      end
    end
    @(negedge clk);
    logLen = 0; burstStarts = 0; burstBad = 0; runCnt = 0;
    mark = riseTotal; d0 = doneCnt; doneWide = 0; lenAtDone = -1;
    start = 1'b1; stepsReq = 9'(steps);
    @(negedge clk);
    start = 1'b0;
    if (pokeBusy) begin
      repeat (100) @(negedge clk);
      start = 1'b1; stepsReq = 9'd7;         // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
      hostWrite(10, 8'hAA);                  // R9: must be ignored
    end
    while (doneCnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    mismatch = 0; firstBad = -1;
    for (int i = 0; i < expLen && i < logLen; i++)
      if (gotLog[i] != expLog[i]) begin
        if (firstBad < 0) firstBad = i;
        mismatch++;
      end
    check(logLen == expLen, {tag, " R6 R8 stream length"}, logLen, expLen);
    check(mismatch == 0, {tag, " R2 R3 R9 R10 stream content"},
          firstBad < 0 ? 0 : gotLog[firstBad], firstBad < 0 ? 0 : expLog[firstBad]);
    bs = burstStarts;
    check(bs == 2 * steps, {tag, " R4 windows used"}, bs, 2 * steps);
    check(burstBad == 0, {tag, " R4 R5 chunk length and window"}, burstBad, 0);
    check(doneCnt - d0 == 1 && doneWide == 0, {tag, " R7 single done pulse"}, doneCnt - d0, 1);
    check(lenAtDone == expLen, {tag, " R7 done after last byte"}, lenAtDone, expLen);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    check(!palIdxWr && !palDataWr && !done, "R1 reset outputs", int'({palIdxWr, palDataWr, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!palIdxWr && !palDataWr && !done, "R1 idle after reset", int'({palIdxWr, palDataWr, done}), 0);

    // pattern A: zeros, ones, twos and random bytes (R9 idle load)
    for (int i = 0; i < TOTAL; i++) begin
      int v;
      case (i % 7)
        0: v = 0;
        1: v = 1;
        2: v = 2;
        3: v = 255;
        default: v = int'($urandom % 256);
      endcase
      model[i] = v;
      hostWrite(i, v);
    end
    runFade(3, 1'b0, "A3");
    runFade(2, 1'b1, "busy");
    runFade(0, 1'b0, "zero");

    // pattern B: address ramp, start inside a long open window
    for (int i = 0; i < TOTAL; i++) begin
      model[i] = i % 256;
      hostWrite(i, i % 256);
    end
    longHigh = 1'b1;
    while (retrace) @(negedge clk);
    while (!retrace) @(negedge clk);
    repeat (5) @(negedge clk);
    runFade(1, 1'b0, "tailR5");
    longHigh = 1'b0;
    runFade(1 + int'($urandom % 2), 1'b0, "rand");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule